// File: doc/BRIEF.md
# Indirect PCI Cycle Access Unit

This unit lets a local processor run single-word PCI cycles through a small set of memory-mapped registers instead of a direct bus window. Software loads a target address and a command byte. The command byte holds the PCI command code and active-low lane enables. A cycle then starts as a side effect of a register write. A read cycle starts when software writes a read-type command. A write cycle starts when software writes the data word. On the PCI side the unit drives a simplified single-beat request that stays up until the far side acknowledges it. The acknowledge returns read data, or a master-abort flag when no target claimed the cycle.

Only one cycle can be outstanding at a time. While a cycle is in flight, an access that would start another cycle or collect the result holds the processor bus off with a ready signal. It completes once the response has been absorbed. Failures never reach the processor as bus errors. They appear only as sticky, write-one-to-clear status flags. These flags, masked by an enable register, form a single interrupt line.

Top module: `pci_indirect_port`

## Requirements
- R1: After a synchronous reset every register reads zero, `pci_req` is low and `irq` is low.
- R2: Register map (byte offsets): 0x00 target address (32 bits), 0x04 command byte, 0x08 write data, 0x0C read result, 0x20 status, 0x24 interrupt enable. The command byte keeps the PCI command in bits [3:0] and the active-low lane enables in bits [7:4]. A single byte at lane n is 0xF with bit n cleared, and a full word is 0000. The command byte, status and enable registers keep 8 bits, and their upper bits read zero. Any other offset reads zero.
- R3: A write to 0x04 whose command bit 0 is 0 is a read-type launch. Read commands are 0x2 I/O, 0x6 memory and 0xA configuration. On the next cycle `pci_req` rises. The request carries the address register, the new command in `pci_cmd` and the new lane enables in `pci_be_n`. It stays high until the cycle in which `pci_ack` is sampled.
- R4: A write to 0x08 launches a cycle with the stored command byte and the written word on `pci_wdata`. Write commands are 0x3 I/O, 0x7 memory and 0xB configuration. A write to 0x04 with command bit 0 set starts nothing.
- R5: When a read-type cycle is acknowledged without abort, `pci_rdata` is stored in 0x0C. A write-type cycle that completes normally leaves 0x0C unchanged.
- R6: When a cycle is acknowledged with `pci_mabort` high, status bit 1 is set and 0x0C is loaded with 0xFFFFFFFF.
- R7: While a cycle is outstanding, a read of 0x0C or a write to 0x04 or 0x08 holds `cpu_ready` low. That access completes in the cycle after the acknowledge, and a held launch then starts exactly one new cycle. Other accesses are never held.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. A set event in the same cycle as a clear wins. Status bits [7:4] always read zero.
- R9: A pulse on `err_evt[0]` sets status bit 0, `err_evt[1]` sets bit 2 and `err_evt[2]` sets bit 3.
- R10: `irq` is high exactly when some status bit and the matching enable bit are both 1.
- R11: Address, command, lane enables and write data on the PCI side do not change while a request is outstanding, even if the registers are rewritten meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Processor access valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Byte offset of the register |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, valid when ready |
| cpu_ready | output | 1 | Access completes on this edge when high |
| pci_req | output | 1 | PCI cycle request, held until acknowledged |
| pci_addr | output | 32 | PCI cycle address |
| pci_cmd | output | 4 | PCI command code |
| pci_be_n | output | 4 | Active-low byte lane enables |
| pci_wdata | output | 32 | PCI write data |
| pci_ack | input | 1 | Response strobe for the outstanding request |
| pci_mabort | input | 1 | With pci_ack: no target responded |
| pci_rdata | input | 32 | With pci_ack: read data |
| err_evt | input | 3 | Error event pulses for status bits 0, 2, 3 |
| irq | output | 1 | Interrupt: OR of enabled status bits |

## Verification
The bench drives accesses that collide with an outstanding cycle. A design without the hold would launch a second request over the first, or return the stale read result. A design that releases the hold one cycle late or early would return stale data or lose the queued write. Command bytes with bit 0 set are written to show that they start nothing, and completed write cycles are checked to leave the read result intact. A design that launched on every command write, or captured bus data on writes, would show a spurious request or a changed result. A clear written in the same cycle as a new error event, and a master abort, show whether the sticky flags favour the event and whether the all-ones fill reaches software.

// File: rtl/pci_ind_pkg.sv
package pci_ind_pkg;

    localparam int PCI_DW  = 32;
    localparam int PCI_BEW = PCI_DW / 8;
    localparam int CMD_W   = 4;
    localparam int STAT_W  = 8;
    localparam int ERR_W   = 3;

    localparam logic [7:0] OFS_TADDR = 8'h00;
    localparam logic [7:0] OFS_CMDBE = 8'h04;
    localparam logic [7:0] OFS_WDATA = 8'h08;
    localparam logic [7:0] OFS_RSLT  = 8'h0C;
    localparam logic [7:0] OFS_STAT  = 8'h20;
    localparam logic [7:0] OFS_INTEN = 8'h24;

    localparam int ABORT_BIT = 1;

    typedef enum logic [2:0] {
        RS_TADDR,
        RS_CMDBE,
        RS_WDATA,
        RS_RSLT,
        RS_STAT,
        RS_INTEN,
        RS_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [PCI_DW-1:0]  addr;
        logic [CMD_W-1:0]   cmd;
        logic [PCI_BEW-1:0] be_n;
        logic [PCI_DW-1:0]  data;
    } pci_cycle_t;

    typedef struct packed {
        logic              done;
        logic              abort;
        logic              is_read;
        logic [PCI_DW-1:0] data;
    } pci_resp_t;

    function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
        return ~c[0];
    endfunction

    function automatic logic [STAT_W-1:0] err_to_stat(input logic [ERR_W-1:0] e,
                                                      input logic abort);
        logic [STAT_W-1:0] v;
        v = '0;
        v[0] = e[0];
        v[ABORT_BIT] = abort;
        v[2] = e[1];
        v[3] = e[2];
        return v;
    endfunction

endpackage

// File: rtl/pci_ind_decode.sv
module pci_ind_decode
    import pci_ind_pkg::*;
#(
    parameter int CPU_AW = 8
) (
    input  logic [CPU_AW-1:0] offset,
    output reg_sel_e          sel
);
    localparam int CW = (CPU_AW < 8) ? CPU_AW : 8;

    logic upper_zero;

    generate
        if (CPU_AW > 8) begin : g_wide
            assign upper_zero = (offset[CPU_AW-1:8] == '0);
        end else begin : g_narrow
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = RS_NONE;
        if (upper_zero) begin
            unique case (offset[CW-1:0])
                OFS_TADDR[CW-1:0]: sel = RS_TADDR;
                OFS_CMDBE[CW-1:0]: sel = RS_CMDBE;
                OFS_WDATA[CW-1:0]: sel = RS_WDATA;
                OFS_RSLT[CW-1:0]:  sel = RS_RSLT;
                OFS_STAT[CW-1:0]:  sel = RS_STAT;
                OFS_INTEN[CW-1:0]: sel = RS_INTEN;
                default:           sel = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pci_ind_engine.sv
module pci_ind_engine
    import pci_ind_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_wr,
    input  reg_sel_e           acc_sel,
    input  logic [PCI_DW-1:0]  acc_wdata,
    input  logic [PCI_DW-1:0]  taddr_q,
    input  logic [7:0]         cmdbe_q,
    output logic               hold,
    output logic               busy,
    output pci_cycle_t         cyc,
    input  logic               pci_ack,
    input  logic               pci_mabort,
    input  logic [PCI_DW-1:0]  pci_rdata,
    output pci_resp_t          resp
);
    logic       req_is_read_q;
    logic       launch_rd, launch_wr, launch;
    logic       wants_wait;
    pci_cycle_t nxt_cyc;

    assign launch_rd = acc_valid & acc_wr & (acc_sel == RS_CMDBE)
                     & cmd_is_read(acc_wdata[CMD_W-1:0]);
    assign launch_wr = acc_valid & acc_wr & (acc_sel == RS_WDATA);

    assign wants_wait = acc_valid &
                        ((acc_wr  & ((acc_sel == RS_CMDBE) | (acc_sel == RS_WDATA))) |
                         (~acc_wr & (acc_sel == RS_RSLT)));
    assign hold   = busy & wants_wait;
    assign launch = (launch_rd | launch_wr) & ~busy;

    always_comb begin
        nxt_cyc.addr = taddr_q;
        if (launch_rd) begin
            nxt_cyc.cmd  = acc_wdata[CMD_W-1:0];
            nxt_cyc.be_n = acc_wdata[CMD_W+PCI_BEW-1:CMD_W];
            nxt_cyc.data = '0;
        end else begin
            nxt_cyc.cmd  = cmdbe_q[CMD_W-1:0];
            nxt_cyc.be_n = cmdbe_q[CMD_W+PCI_BEW-1:CMD_W];
            nxt_cyc.data = acc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            cyc           <= '0;
            req_is_read_q <= 1'b0;
        end else if (launch) begin
            busy          <= 1'b1;
            cyc           <= nxt_cyc;
            req_is_read_q <= launch_rd;
        end else if (busy && pci_ack) begin
            busy          <= 1'b0;
        end
    end

    assign resp.done    = busy & pci_ack;
    assign resp.abort   = busy & pci_ack & pci_mabort;
    assign resp.is_read = req_is_read_q;
    assign resp.data    = pci_rdata;

    p_fields_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !pci_ack) |=> (busy && $stable(cyc)));
    p_release_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && pci_ack) |=> !busy);
    p_no_double_launch_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !pci_ack && wants_wait) |-> hold);

endmodule

// File: rtl/pci_ind_regs.sv
module pci_ind_regs
    import pci_ind_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_we,
    input  reg_sel_e           acc_sel,
    input  logic [PCI_DW-1:0]  acc_wdata,
    input  pci_resp_t          resp,
    input  logic [ERR_W-1:0]   err_evt,
    output logic [PCI_DW-1:0]  taddr_q,
    output logic [7:0]         cmdbe_q,
    output logic [PCI_DW-1:0]  rd_mux,
    output logic               irq
);
    logic [PCI_DW-1:0] wdata_q;
    logic [PCI_DW-1:0] rslt_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] inten_q;
    logic [STAT_W-1:0] stat_set, stat_clr;

    assign stat_set = err_to_stat(err_evt, resp.abort);
    assign stat_clr = (acc_we && acc_sel == RS_STAT) ? acc_wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            taddr_q <= '0;
            cmdbe_q <= '0;
            wdata_q <= '0;
            inten_q <= '0;
        end else if (acc_we) begin
            unique case (acc_sel)
                RS_TADDR: taddr_q <= acc_wdata;
                RS_CMDBE: cmdbe_q <= acc_wdata[7:0];
                RS_WDATA: wdata_q <= acc_wdata;
                RS_INTEN: inten_q <= acc_wdata[STAT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rslt_q <= '0;
        end else if (resp.done) begin
            if (resp.abort)
                rslt_q <= '1;
            else if (resp.is_read)
                rslt_q <= resp.data;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < STAT_W; gi++) begin : g_stat
            always_ff @(posedge clk) begin
                if (rst)
                    stat_q[gi] <= 1'b0;
                else if (stat_set[gi])
                    stat_q[gi] <= 1'b1;
                else if (stat_clr[gi])
                    stat_q[gi] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |(stat_q & inten_q);

    always_comb begin
        unique case (acc_sel)
            RS_TADDR: rd_mux = taddr_q;
            RS_CMDBE: rd_mux = {{(PCI_DW-8){1'b0}}, cmdbe_q};
            RS_WDATA: rd_mux = wdata_q;
            RS_RSLT:  rd_mux = rslt_q;
            RS_STAT:  rd_mux = {{(PCI_DW-STAT_W){1'b0}}, stat_q};
            RS_INTEN: rd_mux = {{(PCI_DW-STAT_W){1'b0}}, inten_q};
            default:  rd_mux = '0;
        endcase
    end

    p_abort_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (resp.done && resp.abort) |=> (stat_q[ABORT_BIT] && (&rslt_q)));
    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_we && acc_sel == RS_STAT && acc_wdata[ABORT_BIT] && !resp.abort)
        |=> !stat_q[ABORT_BIT]);
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        stat_q[STAT_W-1:4] == '0);
    p_write_keeps_result_r5: assert property (@(posedge clk) disable iff (rst)
        (resp.done && !resp.abort && !resp.is_read) |=> $stable(rslt_q));

endmodule

// File: rtl/pci_indirect_port.sv
module pci_indirect_port
    import pci_ind_pkg::*;
#(
    parameter int CPU_AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_sel,
    input  logic                cpu_wr,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [PCI_DW-1:0]   cpu_wdata,
    output logic [PCI_DW-1:0]   cpu_rdata,
    output logic                cpu_ready,
    output logic                pci_req,
    output logic [PCI_DW-1:0]   pci_addr,
    output logic [CMD_W-1:0]    pci_cmd,
    output logic [PCI_BEW-1:0]  pci_be_n,
    output logic [PCI_DW-1:0]   pci_wdata,
    input  logic                pci_ack,
    input  logic                pci_mabort,
    input  logic [PCI_DW-1:0]   pci_rdata,
    input  logic [ERR_W-1:0]    err_evt,
    output logic                irq
);
    reg_sel_e          sel;
    logic              hold, busy;
    pci_cycle_t        cyc;
    pci_resp_t         resp;
    logic [PCI_DW-1:0] taddr_q;
    logic [7:0]        cmdbe_q;
    logic [PCI_DW-1:0] rd_mux;
    logic              acc_we;

    pci_ind_decode #(.CPU_AW(CPU_AW)) u_dec (
        .offset (cpu_addr),
        .sel    (sel)
    );

    pci_ind_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (cpu_sel),
        .acc_wr     (cpu_wr),
        .acc_sel    (sel),
        .acc_wdata  (cpu_wdata),
        .taddr_q    (taddr_q),
        .cmdbe_q    (cmdbe_q),
        .hold       (hold),
        .busy       (busy),
        .cyc        (cyc),
        .pci_ack    (pci_ack),
        .pci_mabort (pci_mabort),
        .pci_rdata  (pci_rdata),
        .resp       (resp)
    );

    assign acc_we = cpu_sel & cpu_wr & ~hold;

    pci_ind_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc_we    (acc_we),
        .acc_sel   (sel),
        .acc_wdata (cpu_wdata),
        .resp      (resp),
        .err_evt   (err_evt),
        .taddr_q   (taddr_q),
        .cmdbe_q   (cmdbe_q),
        .rd_mux    (rd_mux),
        .irq       (irq)
    );

    assign cpu_ready = ~hold;
    assign cpu_rdata = rd_mux;
    assign pci_req   = busy;
    assign pci_addr  = cyc.addr;
    assign pci_cmd   = cyc.cmd;
    assign pci_be_n  = cyc.be_n;
    assign pci_wdata = cyc.data;

    p_hold_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
        !cpu_ready |-> pci_req);
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pci_req && !irq));

endmodule

// File: tb/pci_indirect_port_tb_top.sv
module pci_indirect_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        pci_req;
    logic [31:0] pci_addr, pci_wdata;
    logic [3:0]  pci_cmd, pci_be_n;
    logic        pci_ack = 1'b0, pci_mabort = 1'b0;
    logic [31:0] pci_rdata = '0;
    logic [2:0]  err_evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pci_indirect_port dut_i (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .pci_req(pci_req), .pci_addr(pci_addr),
        .pci_cmd(pci_cmd), .pci_be_n(pci_be_n), .pci_wdata(pci_wdata),
        .pci_ack(pci_ack), .pci_mabort(pci_mabort), .pci_rdata(pci_rdata),
        .err_evt(err_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // ---------------- PCI responder ----------------
    int          rsp_lat = 2;
    logic        rsp_abort = 1'b0;
    logic [31:0] rsp_data = '0;
    int          req_count = 0;
    logic [31:0] seen_addr, seen_wdata;
    logic [3:0]  seen_cmd, seen_be;

    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (pci_ack) begin
                pci_ack = 1'b0;
                pci_mabort = 1'b0;
            end else if (pci_req) begin
                if (wcnt == 0) begin
                    seen_addr = pci_addr; seen_cmd = pci_cmd;
                    seen_be = pci_be_n;   seen_wdata = pci_wdata;
                end else begin
                    check("R11 addr held", pci_addr, seen_addr);
                    check("R11 data held", pci_wdata, seen_wdata);
                    check("R11 cmd/be held", {24'h0, pci_cmd, pci_be_n}, {24'h0, seen_cmd, seen_be});
                end
                wcnt++;
                if (wcnt >= rsp_lat) begin
                    pci_ack = 1'b1;
                    pci_mabort = rsp_abort;
                    pci_rdata = rsp_data;
                    wcnt = 0;
                    req_count++;
                end
            end
        end
    end

    // ---------------- cycle-level reference model ----------------
    logic       m_busy = 1'b0;
    logic [7:0] m_stat = '0, m_en = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0; m_stat <= '0; m_en <= '0;
        end else begin
            logic [7:0] set_v, nxt;
            set_v = {4'b0, err_evt[2], err_evt[1], m_busy && pci_ack && pci_mabort, err_evt[0]};
            nxt = m_stat;
            if (cpu_sel && cpu_wr && cpu_ready && cpu_addr == 8'h20)
                nxt = nxt & ~cpu_wdata[7:0];
            m_stat <= nxt | set_v;
            if (cpu_sel && cpu_wr && cpu_ready && cpu_addr == 8'h24)
                m_en <= cpu_wdata[7:0];
            if (m_busy && pci_ack)
                m_busy <= 1'b0;
            else if (!m_busy && cpu_sel && cpu_wr &&
                     (cpu_addr == 8'h08 || (cpu_addr == 8'h04 && !cpu_wdata[0])))
                m_busy <= 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R10 irq vs model", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
            check("R7 req vs model", {31'b0, pci_req}, {31'b0, m_busy});
        end
    end

    // ---------------- bus access ----------------
    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int waits);
        waits = 0;
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r; int w;
        bus(1'b1, a, d, r, w);
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] r);
        int w;
        bus(1'b0, a, 32'h0, r, w);
    endtask

    task automatic wait_idle();
        while (pci_req) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int w, cnt0;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        foreach (r[i]) ; // no-op
        begin
            logic [7:0] offs [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24};
            foreach (offs[i]) begin
                rd32(offs[i], r);
                check("R1 reset register", r, 32'h0);
            end
        end
        check("R1 reset req/irq", {30'b0, pci_req, irq}, 32'h0);

        // R2 readback and R4 odd command starts nothing
        wr32(8'h00, 32'h1234_5678);
        rd32(8'h00, r); check("R2 address readback", r, 32'h1234_5678);
        wr32(8'h04, 32'hFFFF_F1FB);
        rd32(8'h04, r); check("R2 command byte readback", r, 32'h0000_00FB);
        check("R4 odd command no launch", {31'b0, pci_req}, 32'h0);
        check("R4 odd command no launch count", req_count, 0);
        wr32(8'h24, 32'hFFFF_FF00);
        rd32(8'h24, r); check("R2 enable readback", r, 32'h0);
        rd32(8'h10, r); check("R2 unmapped offset", r, 32'h0);

        // R3 read launch, R5 capture, R7 stall on result read
        rsp_lat = 4; rsp_data = 32'hCAFE_F00D; rsp_abort = 1'b0;
        wr32(8'h00, 32'h0000_0810);
        wr32(8'h04, 32'h0000_000A);
        bus(1'b0, 8'h0C, 32'h0, r, w);
        check("R5 config read result", r, 32'hCAFE_F00D);
        check("R7 result read was held", {31'b0, (w > 0)}, 32'h1);
        check("R3 request address", seen_addr, 32'h0000_0810);
        check("R3 request cmd", {28'h0, seen_cmd}, 32'hA);
        check("R3 request full-word enables", {28'h0, seen_be}, 32'h0);

        // R3 byte read on lane 2 (enables 1011)
        rsp_lat = 1; rsp_data = 32'h00AB_0000;
        wr32(8'h04, 32'h0000_00B6);
        rd32(8'h0C, r);
        check("R5 memory byte read", r, 32'h00AB_0000);
        check("R3 lane-2 byte enables", {28'h0, seen_be}, 32'hB);
        check("R3 memory read cmd", {28'h0, seen_cmd}, 32'h6);

        // R4 write launch, R5 result untouched by write
        rsp_lat = 3; rsp_data = 32'h5555_5555;
        wr32(8'h00, 32'h0000_2000);
        wr32(8'h04, 32'h0000_00C7);
        check("R4 command write no launch", {31'b0, pci_req}, 32'h0);
        wr32(8'h08, 32'hDEAD_BEEF);
        wait_idle();
        check("R4 write data", seen_wdata, 32'hDEAD_BEEF);
        check("R4 write cmd", {28'h0, seen_cmd}, 32'h7);
        check("R4 half-word enables", {28'h0, seen_be}, 32'hC);
        rd32(8'h0C, r); check("R5 write keeps result", r, 32'h00AB_0000);

        // R7 + R11 back-to-back writes with address rewrite
        rsp_lat = 6;
        cnt0 = req_count;
        wr32(8'h08, 32'h1111_1111);
        wr32(8'h00, 32'h0000_3000);     // not held, latched request unchanged
        check("R11 address during cycle", pci_addr, 32'h0000_2000);
        bus(1'b1, 8'h08, 32'h2222_2222, r, w);
        check("R7 second launch held", {31'b0, (w > 0)}, 32'h1);
        wait_idle();
        check("R7 exactly two cycles", req_count - cnt0, 2);
        check("R7 second cycle data", seen_wdata, 32'h2222_2222);
        check("R11 second cycle new address", seen_addr, 32'h0000_3000);

        // R6 master abort, R10 irq
        rsp_lat = 2; rsp_abort = 1'b1;
        wr32(8'h04, 32'h0000_0002);
        rd32(8'h0C, r);
        check("R6 abort fills ones", r, 32'hFFFF_FFFF);
        rsp_abort = 1'b0;
        rd32(8'h20, r); check("R6 abort flag", r, 32'h0000_0002);
        check("R10 irq masked", {31'b0, irq}, 32'h0);
        wr32(8'h24, 32'h0000_0002);
        @(negedge clk);
        check("R10 irq enabled", {31'b0, irq}, 32'h1);

        // R8 write-one-to-clear
        wr32(8'h20, 32'h0000_0000);
        rd32(8'h20, r); check("R8 zero write keeps", r, 32'h0000_0002);
        wr32(8'h20, 32'hFFFF_FF02);
        rd32(8'h20, r); check("R8 one clears", r, 32'h0);
        check("R10 irq drops", {31'b0, irq}, 32'h0);

        // R9 error events
        @(negedge clk); err_evt = 3'b111;
        @(negedge clk); err_evt = 3'b000;
        rd32(8'h20, r); check("R9 error flags", r, 32'h0000_000D);
        wr32(8'h20, 32'h0000_0005);
        rd32(8'h20, r); check("R8 partial clear", r, 32'h0000_0008);

        // R8 set beats clear in the same cycle
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = 8'h20; cpu_wdata = 32'h0000_000F;
        err_evt = 3'b100;
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_wr = 1'b0; err_evt = 3'b000;
        rd32(8'h20, r); check("R8 set wins over clear", r, 32'h0000_0008);
        wr32(8'h20, 32'h0000_00F0);
        rd32(8'h20, r); check("R8 upper bits stay zero", r, 32'h0000_0008);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule